// File: doc/BRIEF.md
# Modulo-Divided Asynchronous Serial Transceiver

This block is a full-duplex, two-wire asynchronous serial port for a microcontroller-class bus. A 13-bit modulo divisor turns the bus clock into a tick at 16 times the bit rate. The transmitter and the receiver both count these ticks. Each direction holds one byte beyond its shift register. On the transmit side a byte can be queued while another is on the line. On the receive side a finished byte waits while the next one shifts in. The block also generates and checks parity, sends a normal or long break, and has a sleep mode in which the receiver ignores traffic until the line goes idle.

Bytes to be sent enter on a valid/ready stream. A byte is taken on any clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` stays low for as long as the holding register is occupied. Received bytes leave on a second valid/ready stream. `rx_valid` holds the byte and its error flags steady until a clock edge with `rx_ready` high takes them. The receive side never stalls the line: if a byte completes while the previous one has not been taken, the new byte is lost and an overrun is flagged. Configuration inputs (divisor, parity, break length) are plain levels. They are meant to change only while both directions are idle.

Top module: `serial_xcvr`

## Requirements
- R1: A baud tick occurs once every `divisor` clocks. Each serial bit lasts 16 ticks, which is 16×divisor clocks. A divisor of 0 stops the tick, so a queued byte does not start and `txd` stays high.
- R2: A transmitted frame is one low start bit, then 8 data bits with bit 0 first, then the parity bit if it is enabled, then one high stop bit. The line rests high when nothing is being sent.
- R3: `tx_ready` is high exactly while the holding register is empty. One byte can be accepted while another shifts out, and `tx_ready` then stays low until the shifter takes the queued byte.
- R4: `tx_done` is high only when the holding register, the shifter and any pending break are all empty. It drops on the clock after a byte is accepted and rises again only after the last stop bit has ended.
- R5: With `parity_en` set, the parity bit equals the XOR of the 8 data bits XOR `parity_odd` (0 gives even parity, 1 gives odd). The transmitter sends this bit. The receiver sets `rx_perr` with the byte when the received parity bit differs from it.
- R6: The receiver starts a frame on the first tick at which the line is low, and numbers that tick sample 0. Each bit's value is the majority of samples 7, 8 and 9. A start bit whose majority is high is discarded as a glitch, and no byte results.
- R7: A completed byte is presented on `rx_data` with `rx_valid` high. It stays stable until it is taken with `rx_ready`, and the next frame can shift in meanwhile.
- R8: If a frame completes while `rx_valid` is high and `rx_ready` is low, the new byte is dropped, `rx_data` keeps the old byte and `rx_ovr` is set. `rx_ovr` clears when the held byte is taken.
- R9: If the stop bit's majority value is low, `rx_ferr` is set together with the byte.
- R10: A pulse on `sleep_req` sets `asleep`. While asleep, no byte is delivered. `asleep` clears after a full character time of unbroken high line, which is 16×(10, or 11 with parity) ticks.
- R11: A pulse on `brk_req` sends a break. The line goes low for 10 bit times, or 13 when `long_break` is set, starting at the next tick when the shifter is free. A pending break goes ahead of a queued byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 13 | Modulo baud divisor, 0 disables |
| parity_en | input | 1 | Add and check a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| long_break | input | 1 | Break length 13 bit times instead of 10 |
| brk_req | input | 1 | Pulse to request one break |
| sleep_req | input | 1 | Pulse to put the receiver to sleep |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Holding register free |
| tx_done | output | 1 | Transmitter fully idle |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds an untaken byte |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_perr | output | 1 | Parity mismatch for the held byte |
| rx_ferr | output | 1 | Stop bit low for the held byte |
| rx_ovr | output | 1 | A byte was lost while one was held |
| asleep | output | 1 | Receiver sleeping until idle line |

## Verification
The hardest state to reach from the ports is a sleeping receiver that has to stay asleep through real traffic and then wake only on a genuine idle gap. This works only if frames arrive back to back, with no high stretch as long as a character. The bench pulses `sleep_req` and starts driving frames on the very next cycle. The data values are chosen so that no run of high bits comes close to the wake threshold. Only after that does the bench leave the line idle and confirm that the next byte is delivered. Overrun is reached by withholding `rx_ready` across two whole frames. A rejected start bit is produced by a low pulse shorter than half a bit.

// File: rtl/serial_xcvr_pkg.sv
package serial_xcvr_pkg;
  localparam int OVERSAMPLE = 16;
  localparam int SUB_W      = $clog2(OVERSAMPLE);

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/serial_baud.sv
module serial_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (divisor == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  assert_zero_div_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |=> !tick);
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_xcvr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NORM_BRK = 10,
  parameter int LONG_BRK = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              long_break,
  input  logic              brk_req,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_done,
  output logic              txd
);
  localparam int SH_W    = DATA_W + 3;
  localparam int BRK_MAX = (LONG_BRK > NORM_BRK) ? LONG_BRK : NORM_BRK;
  localparam int LEN_MAX = (BRK_MAX > SH_W) ? BRK_MAX : SH_W;
  localparam int CW      = $clog2(LEN_MAX + 1);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full, brk_pend;
  logic              busy, brk_mode;
  logic [SH_W-1:0]   shreg, frame;
  logic [SUB_W-1:0]  sub;
  logic [CW-1:0]     idx, nbits;
  logic              accept, load_brk, load_frame;

  assign accept     = tx_valid && !hold_full;
  assign load_brk   = tick && !busy && brk_pend;
  assign load_frame = tick && !busy && !brk_pend && hold_full;

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    frame[DATA_W:1] = hold_q;
    if (parity_en) frame[DATA_W+1] = (^hold_q) ^ parity_odd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      brk_pend  <= 1'b0;
    end else begin
      if (accept) hold_q <= tx_data;
      hold_full <= accept | (hold_full & !load_frame);
      brk_pend  <= brk_req | (brk_pend & !load_brk);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      brk_mode <= 1'b0;
      shreg    <= '1;
      sub      <= '0;
      idx      <= '0;
      nbits    <= '0;
    end else if (tick) begin
      if (!busy) begin
        if (load_brk) begin
          busy     <= 1'b1;
          brk_mode <= 1'b1;
          shreg    <= '1;
          sub      <= '0;
          idx      <= '0;
          nbits    <= long_break ? CW'(LONG_BRK) : CW'(NORM_BRK);
        end else if (load_frame) begin
          busy     <= 1'b1;
          brk_mode <= 1'b0;
          shreg    <= frame;
          sub      <= '0;
          idx      <= '0;
          nbits    <= parity_en ? CW'(DATA_W + 3) : CW'(DATA_W + 2);
        end
      end else if (sub == SUB_W'(OVERSAMPLE - 1)) begin
        sub   <= '0;
        shreg <= {1'b1, shreg[SH_W-1:1]};
        if (idx == nbits - 1'b1) begin
          busy     <= 1'b0;
          brk_mode <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign tx_ready = !hold_full;
  assign tx_done  = !busy && !hold_full && !brk_pend;
  assign txd      = busy ? (!brk_mode && shreg[0]) : 1'b1;

  assert_hold_drains_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !tick) |=> hold_full);
  assert_done_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_done);
  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd);
  assert_break_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && brk_mode) |-> !txd);
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              asleep,
  output logic              line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_ovr
);
  localparam int IW = $clog2(DATA_W + 3);

  logic [1:0]        sync_q;
  logic              active, s7, s8, pbit;
  logic [SUB_W-1:0]  sub;
  logic [IW-1:0]     idx, stop_idx;
  logic [DATA_W-1:0] sh;
  logic              mid, maj, frame_end, consume, load, lose;

  assign line      = sync_q[1];
  assign stop_idx  = parity_en ? IW'(DATA_W + 2) : IW'(DATA_W + 1);
  assign mid       = tick && active && (sub == SUB_W'(9));
  assign maj       = maj3(s7, s8, line);
  assign frame_end = mid && (idx == stop_idx);
  assign consume   = rx_valid && rx_ready;
  assign load      = frame_end && !asleep && (!rx_valid || rx_ready);
  assign lose      = frame_end && !asleep && rx_valid && !rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sub    <= '0;
      idx    <= '0;
      s7     <= 1'b1;
      s8     <= 1'b1;
      pbit   <= 1'b0;
      sh     <= '0;
    end else if (tick) begin
      if (!active) begin
        if (!line) begin
          active <= 1'b1;
          sub    <= SUB_W'(1);
          idx    <= '0;
        end
      end else begin
        if (sub == SUB_W'(7)) s7 <= line;
        if (sub == SUB_W'(8)) s8 <= line;
        if (sub == SUB_W'(9)) begin
          if (idx == '0) begin
            if (maj) active <= 1'b0;
          end else if (idx <= IW'(DATA_W)) begin
            sh <= {maj, sh[DATA_W-1:1]};
          end else if (idx == stop_idx) begin
            active <= 1'b0;
          end else begin
            pbit <= maj;
          end
        end
        sub <= sub + 1'b1;
        if (sub == SUB_W'(OVERSAMPLE - 1)) idx <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_ovr   <= 1'b0;
    end else begin
      if (load) begin
        rx_data  <= sh;
        rx_valid <= 1'b1;
        rx_perr  <= parity_en && (pbit != ((^sh) ^ parity_odd));
        rx_ferr  <= !maj;
      end else if (consume) begin
        rx_valid <= 1'b0;
      end
      if (lose)         rx_ovr <= 1'b1;
      else if (consume) rx_ovr <= 1'b0;
    end
  end

  assert_held_byte_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid));
  assert_asleep_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !rx_valid) |=> !rx_valid);
endmodule

// File: rtl/serial_wake.sv
module serial_wake
  import serial_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic parity_en,
  input  logic sleep_req,
  output logic asleep
);
  localparam int LIM_MAX = OVERSAMPLE * (DATA_W + 3);
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt, limit;

  assign limit = parity_en ? CW'(OVERSAMPLE * (DATA_W + 3)) : CW'(OVERSAMPLE * (DATA_W + 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep <= 1'b0;
      cnt    <= '0;
    end else if (sleep_req) begin
      asleep <= 1'b1;
      cnt    <= '0;
    end else if (asleep && tick) begin
      if (!line) begin
        cnt <= '0;
      end else if (cnt == limit - 1'b1) begin
        cnt    <= '0;
        asleep <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_wake_on_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(line));
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
  parameter int DIV_W    = 13,
  parameter int DATA_W   = 8,
  parameter int NORM_BRK = 10,
  parameter int LONG_BRK = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              long_break,
  input  logic              brk_req,
  input  logic              sleep_req,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_done,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_ovr,
  output logic              asleep
);
  logic tick, line;

  serial_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  serial_tx #(.DATA_W(DATA_W), .NORM_BRK(NORM_BRK), .LONG_BRK(LONG_BRK)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .parity_en(parity_en),
    .parity_odd(parity_odd), .long_break(long_break), .brk_req(brk_req),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_done(tx_done), .txd(txd)
  );

  serial_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .parity_en(parity_en),
    .parity_odd(parity_odd), .asleep(asleep), .line(line), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
  );

  serial_wake #(.DATA_W(DATA_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line),
    .parity_en(parity_en), .sleep_req(sleep_req), .asleep(asleep)
  );
endmodule

// File: tb/tb_serial_xcvr.sv
module tb_serial_xcvr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] divisor = 13'd4;
  logic        parity_en = 1'b0, parity_odd = 1'b0, long_break = 1'b0;
  logic        brk_req = 1'b0, sleep_req = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_done, txd;
  logic        loop = 1'b0, drv = 1'b1;
  logic        rxd;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_perr, rx_ferr, rx_ovr, asleep;
  logic        rx_ready = 1'b0;
  int          checks = 0, errors = 0, cycles = 0;
  bit          finished = 1'b0;

  assign rxd = loop ? txd : drv;

  always #2 clk = ~clk;

  serial_xcvr dut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .parity_en(parity_en),
    .parity_odd(parity_odd), .long_break(long_break), .brk_req(brk_req),
    .sleep_req(sleep_req), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_done(tx_done), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .asleep(asleep)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int bitp();
    return 16 * int'(divisor);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] d);
    int t = 0;
    @(negedge clk);
    while (!tx_ready && t < 20000) begin @(negedge clk); t++; end
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic consume();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic capture_tx(output logic [7:0] d, output logic p, output logic stp);
    int t = 0;
    int P = bitp();
    d = 8'h00; p = 1'b0; stp = 1'b0;
    @(negedge clk);
    while (txd && t < 20000) begin @(negedge clk); t++; end
    clocks(P / 2);
    for (int i = 0; i < 8; i++) begin clocks(P); d[i] = txd; end
    if (parity_en) begin clocks(P); p = txd; end
    clocks(P); stp = txd;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic badpar, input logic stopv,
                         input logic glitch0);
    int P = bitp();
    @(negedge clk);
    drv = 1'b0; clocks(P);
    for (int i = 0; i < 8; i++) begin
      if (glitch0 && i == 0) begin
        drv = ~d[i]; clocks(8); drv = d[i]; clocks(P - 8);
      end else begin
        drv = d[i]; clocks(P);
      end
    end
    if (parity_en) begin drv = exp_par(d, parity_odd) ^ badpar; clocks(P); end
    drv = stopv; clocks(P);
    drv = 1'b1;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!tx_done && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic measure_low(output int n);
    int t = 0;
    n = 0;
    @(negedge clk);
    while (txd && t < 20000) begin @(negedge clk); t++; end
    while (!txd && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [7:0] a, b, d;
    logic p, s;
    int n, seed;
    seed = $urandom(32'd4242);
    clocks(4);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R3 reset tx_ready", tx_ready, 1);
    chk("R4 reset tx_done", tx_done, 1);
    chk("R2 reset txd idle", txd, 1);
    chk("R7 reset rx_valid", rx_valid, 0);
    chk("R10 reset asleep", asleep, 0);

    // R2 R3 R4: queue two bytes back to back
    fork
      begin
        capture_tx(a, p, s);
        chk("R2 first byte", a, 8'hA5);
        chk("R2 first stop", s, 1);
        capture_tx(b, p, s);
        chk("R3 second byte", b, 8'h3C);
      end
      begin
        push_tx(8'hA5);
        push_tx(8'h3C);
        @(negedge clk);
        chk("R3 both occupied", tx_ready, 0);
        chk("R4 busy not done", tx_done, 0);
      end
    join
    wait_done();
    chk("R4 done after stop", tx_done, 1);

    // R5 transmit parity
    parity_en = 1'b1; parity_odd = 1'b0;
    fork capture_tx(a, p, s); push_tx(8'h03); join
    chk("R5 even parity bit", p, exp_par(8'h03, 1'b0));
    chk("R5 data with parity", a, 8'h03);
    wait_done();
    parity_odd = 1'b1;
    fork capture_tx(a, p, s); push_tx(8'h0F); join
    chk("R5 odd parity bit", p, exp_par(8'h0F, 1'b1));
    wait_done();

    // R7 basic receive
    parity_en = 1'b0;
    send_rx(8'h5A, 1'b0, 1'b1, 1'b0);
    clocks(4);
    chk("R7 rx_valid", rx_valid, 1);
    chk("R7 rx_data", rx_data, 8'h5A);
    chk("R9 no framing error", rx_ferr, 0);
    consume();
    chk("R7 taken", rx_valid, 0);

    // R5 receive parity check
    parity_en = 1'b1; parity_odd = 1'b0;
    send_rx(8'h33, 1'b1, 1'b1, 1'b0);
    clocks(4);
    chk("R5 bad parity flagged", rx_perr, 1);
    consume();
    send_rx(8'h33, 1'b0, 1'b1, 1'b0);
    clocks(4);
    chk("R5 good parity clean", rx_perr, 0);
    chk("R5 data", rx_data, 8'h33);
    consume();
    parity_en = 1'b0;

    // R9 framing error
    send_rx(8'hC3, 1'b0, 1'b0, 1'b0);
    clocks(4 * bitp());
    chk("R9 framing error", rx_ferr, 1);
    chk("R9 data", rx_data, 8'hC3);
    consume();
    chk("R6 no bogus byte after low stop", rx_valid, 0);

    // R6 start glitch and bit majority
    @(negedge clk); drv = 1'b0; clocks(8); drv = 1'b1;
    clocks(3 * bitp());
    chk("R6 glitch rejected", rx_valid, 0);
    send_rx(8'h01, 1'b0, 1'b1, 1'b1);
    clocks(4);
    chk("R6 edge glitch ignored", rx_data, 8'h01);
    consume();

    // R8 overrun
    send_rx(8'h11, 1'b0, 1'b1, 1'b0);
    send_rx(8'h22, 1'b0, 1'b1, 1'b0);
    clocks(4);
    chk("R8 overrun set", rx_ovr, 1);
    chk("R8 old byte kept", rx_data, 8'h11);
    consume();
    chk("R8 overrun cleared", rx_ovr, 0);
    chk("R8 dropped byte gone", rx_valid, 0);

    // R10 sleep through back-to-back frames, wake on idle
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk("R10 asleep set", asleep, 1);
    send_rx(8'h12, 1'b0, 1'b1, 1'b0);
    send_rx(8'h34, 1'b0, 1'b1, 1'b0);
    send_rx(8'h56, 1'b0, 1'b1, 1'b0);
    clocks(4);
    chk("R10 nothing delivered", rx_valid, 0);
    chk("R10 still asleep", asleep, 1);
    clocks(12 * bitp());
    chk("R10 woke on idle", asleep, 0);
    send_rx(8'h78, 1'b0, 1'b1, 1'b0);
    clocks(4);
    chk("R10 delivered after wake", rx_data, 8'h78);
    consume();

    // R11 R1 break lengths
    fork measure_low(n); begin @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0; end join
    chk("R11 normal break", n, 10 * bitp());
    wait_done();
    long_break = 1'b1;
    fork measure_low(n); begin @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0; end join
    chk("R11 long break", n, 13 * bitp());
    wait_done();
    long_break = 1'b0;
    divisor = 13'd2;
    fork measure_low(n); begin @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0; end join
    chk("R1 bit time at divisor 2", n, 10 * 32);
    wait_done();

    // R11 break goes ahead of queued byte
    @(negedge clk); brk_req = 1'b1; tx_data = 8'hE7; tx_valid = 1'b1;
    @(negedge clk); brk_req = 1'b0; tx_valid = 1'b0;
    measure_low(n);
    chk("R11 break first", n, 10 * bitp());
    capture_tx(a, p, s);
    chk("R11 byte after break", a, 8'hE7);
    wait_done();

    // R1 divisor zero halts
    divisor = 13'd0;
    push_tx(8'h99);
    clocks(300);
    chk("R1 halted line high", txd, 1);
    chk("R1 halted not done", tx_done, 0);
    divisor = 13'd3;
    capture_tx(a, p, s);
    chk("R1 resumes", a, 8'h99);
    wait_done();

    // random loopback
    loop = 1'b1;
    for (int k = 0; k < 24; k++) begin
      int t;
      divisor    = 13'($urandom_range(1, 4));
      parity_en  = 1'($urandom_range(0, 1));
      parity_odd = 1'($urandom_range(0, 1));
      d = 8'($urandom_range(0, 255));
      clocks(2);
      push_tx(d);
      t = 0;
      while (!rx_valid && t < 20000) begin @(negedge clk); t++; end
      chk("R2 loopback data", rx_data, d);
      chk("R5 loopback parity", rx_perr, 0);
      chk("R9 loopback stop", rx_ferr, 0);
      consume();
      wait_done();
      clocks(bitp());
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule